// File: doc/BRIEF.md
# Stereo Audio Serial Output Port

This block takes a left and a right 18-bit audio sample and sends both, one after the other, on a single serial data line. It has two timing modes. As timing master it makes the bit clock and the word select from a system clock that runs at 256 times the sample rate. As timing slave it follows a bit clock and a word select that come from outside, and it detects their edges after a short synchronizer. Two select inputs choose one of four frame formats. The formats differ in which channel goes first, in the word-select level that marks each channel, and in whether the MSB starts on the first bit clock of a slot or one clock later.

A standby input releases all three port pins to high impedance. On wake-up the data line is held low for a fixed number of frame starts. That number is short when the high-pass filter upstream is off and long when it is on, so that the line carries only settled samples. The block is driven by one controller with three states. ST_SLEEP holds the pins released. ST_MUTE drives zeros while a frame counter runs down. ST_RUN sends data. The transitions are:
- WAKE (ST_SLEEP to ST_MUTE, standby low).
- RELEASE (ST_MUTE to ST_RUN, at the frame start that empties the counter).
- DOZE (ST_MUTE or ST_RUN to ST_SLEEP, standby high).

Top module: `aud_ser_tx`

## Requirements
- R1: In timing master mode (`slave_mode`=0) the block drives `sck_out` with a period of 4 system clocks (64 times the sample rate). It drives `ws_out` so that it toggles every 128 system clocks, and `sck_oe` and `ws_oe` are 1 while awake.
- R2: `sdo` and `ws_out` change only together with a falling edge of the bit clock, so a receiver samples them on the rising edge.
- R3: Each word-select half is a slot of 32 bit clocks. The slot carries the 18 sample bits MSB first and then zeros. In formats 1 and 3 the MSB sits on bit clock 0 of the slot. In formats 2 and 4 bit clock 0 carries a zero and the MSB sits on bit clock 1.
- R4: Format code from (`fmt_sel`, `fmt_ext`), where `fmt_ext` counts only in slave mode: 10 is format 1, 00 is format 2, 11 is format 3, 01 is format 4. Word select low marks the left channel in formats 2 and 3, and marks the right channel in formats 1 and 4.
- R5: In master mode `fmt_ext` has no effect on the output frame.
- R6: In slave mode the block follows `sck_in` and `ws_in`, keeps `sck_oe` and `ws_oe` at 0, and starts a slot on each falling bit-clock edge at which word select has changed. A pause of the external bit clock inside a slot does not disturb the data.
- R7: A frame opens with the right slot in formats 1 and 3 and with the left slot in formats 2 and 4. Both samples are captured at that frame start, so a sample change in mid-frame first shows in the next frame.
- R8: While `standby` is 1, `sdo_oe`, `sck_oe` and `ws_oe` are all 0 from the next clock on.
- R9: After `standby` falls, `sdo` stays 0 until frame start number N, counting the first frame start after wake-up as number 1. From that frame start on it carries sample data. N is MUTE_SHORT if `hpf_on` was 0 at wake-up and MUTE_LONG if it was 1. In master mode the first data bit appears on the (2 + 256·(N−1))-th clock edge after the release.
- R10: While `rst_n` is low, all three output enables and `sdo` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, 256 times the sample rate |
| rst_n | input | 1 | Asynchronous reset, active low |
| standby | input | 1 | 1 releases all port pins and stops the port |
| slave_mode | input | 1 | 1 means external bit clock and word select |
| fmt_sel | input | 1 | Format select, first bit |
| fmt_ext | input | 1 | Format select, second bit (slave mode only) |
| hpf_on | input | 1 | High-pass filter upstream is on (chooses the long mute) |
| smp_left | input | 18 | Left sample, two's complement |
| smp_right | input | 18 | Right sample, two's complement |
| sck_in | input | 1 | External bit clock (slave mode) |
| ws_in | input | 1 | External word select (slave mode) |
| sck_out | output | 1 | Generated bit clock |
| sck_oe | output | 1 | Drive enable for the bit clock pin |
| ws_out | output | 1 | Generated word select |
| ws_oe | output | 1 | Drive enable for the word-select pin |
| sdo | output | 1 | Serial data |
| sdo_oe | output | 1 | Drive enable for the data pin |

## Verification
The assertions take for granted that `slave_mode` and the format selects stay fixed while the port is awake. They are changed only while `standby` holds the port asleep. In slave mode the data line settles SYNC_STAGES+1 system clocks after an external falling edge. The bench therefore holds each half period of its external bit clock at four system clocks, changes its word select only at a falling edge, and adds its idle pause only while the bit clock is low. Samples stay steady within each stimulus vector, except in the directed test that changes them in mid-frame on purpose.

// File: rtl/aud_ser_pkg.sv
package aud_ser_pkg;
    typedef enum logic [1:0] {
        ST_SLEEP = 2'd0,
        ST_MUTE  = 2'd1,
        ST_RUN   = 2'd2
    } port_state_e;
endpackage

// File: rtl/aud_ser_mtim.sv
// Master timing: one free-running counter gives the bit clock, word select and slot position.
module aud_ser_mtim #(
    parameter int SLOT_W  = 32,
    parameter int SCK_DIV = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      en,
    output logic                      evt,
    output logic                      ws_lvl,
    output logic [$clog2(SLOT_W)-1:0] pos,
    output logic                      new_slot,
    output logic                      sck_o,
    output logic                      ws_o
);
    localparam int DIV_B = $clog2(SCK_DIV);
    localparam int POS_B = $clog2(SLOT_W);
    localparam int CNT_W = DIV_B + POS_B + 1;

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] nx;
    logic             sck_q;
    logic             ws_q;

    assign nx = cnt + CNT_W'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt   <= '1;
            sck_q <= 1'b1;
            ws_q  <= 1'b1;
        end else if (!en) begin
            cnt   <= '1;
            sck_q <= 1'b1;
            ws_q  <= 1'b1;
        end else begin
            cnt   <= nx;
            sck_q <= nx[DIV_B-1];
            ws_q  <= nx[CNT_W-1];
        end
    end

    // Bit event: last phase of a bit period; the next bit is presented on the falling bit clock.
    assign evt      = en && (cnt[DIV_B-1:0] == '1);
    assign pos      = nx[DIV_B +: POS_B];
    assign ws_lvl   = nx[CNT_W-1];
    assign new_slot = (nx[CNT_W-2:0] == '0);
    assign sck_o    = sck_q;
    assign ws_o     = ws_q;

    AST_WS_ON_SCK_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(en) && en && !$stable(ws_q)) |-> $fell(sck_q)); // R2
endmodule

// File: rtl/aud_ser_strk.sv
// Slave tracker: synchronizes the external bit clock and word select and counts slot position.
module aud_ser_strk #(
    parameter int SLOT_W      = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      en,
    input  logic                      sck_i,
    input  logic                      ws_i,
    output logic                      evt,
    output logic                      ws_lvl,
    output logic [$clog2(SLOT_W)-1:0] pos,
    output logic                      new_slot
);
    localparam int POS_B = $clog2(SLOT_W);
    localparam logic [POS_B-1:0] POS_MAX = POS_B'(SLOT_W - 1);

    logic [SYNC_STAGES-1:0] sck_sh;
    logic [SYNC_STAGES-1:0] ws_sh;
    logic                   sck_d;
    logic                   ws_last;
    logic [POS_B-1:0]       pos_q;
    logic                   sck_s;
    logic                   ws_s;
    logic                   fall;

    assign sck_s    = sck_sh[SYNC_STAGES-1];
    assign ws_s     = ws_sh[SYNC_STAGES-1];
    assign fall     = sck_d && !sck_s;
    assign evt      = en && fall;
    assign ws_lvl   = ws_s;
    assign new_slot = (ws_s != ws_last);
    assign pos      = new_slot ? '0 : ((pos_q == POS_MAX) ? POS_MAX : pos_q + POS_B'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_sh  <= '0;
            ws_sh   <= '0;
            sck_d   <= 1'b0;
            ws_last <= 1'b0;
            pos_q   <= POS_MAX;
        end else begin
            sck_sh <= {sck_sh[SYNC_STAGES-2:0], sck_i};
            ws_sh  <= {ws_sh[SYNC_STAGES-2:0], ws_i};
            sck_d  <= sck_s;
            if (!en) begin
                ws_last <= ws_s;
                pos_q   <= POS_MAX;
            end else if (fall) begin
                ws_last <= ws_s;
                pos_q   <= pos;
            end
        end
    end

    AST_SLOT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (en && fall && (ws_s != ws_last)) |=> (pos_q == '0)); // R6
endmodule

// File: rtl/aud_ser_tx.sv
module aud_ser_tx
    import aud_ser_pkg::*;
#(
    parameter int SMP_W       = 18,
    parameter int SLOT_W      = 32,
    parameter int SCK_DIV     = 4,
    parameter int SYNC_STAGES = 2,
    parameter int MUTE_SHORT  = 1024,
    parameter int MUTE_LONG   = 12288
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             standby,
    input  logic             slave_mode,
    input  logic             fmt_sel,
    input  logic             fmt_ext,
    input  logic             hpf_on,
    input  logic [SMP_W-1:0] smp_left,
    input  logic [SMP_W-1:0] smp_right,
    input  logic             sck_in,
    input  logic             ws_in,
    output logic             sck_out,
    output logic             sck_oe,
    output logic             ws_out,
    output logic             ws_oe,
    output logic             sdo,
    output logic             sdo_oe
);
    localparam int POS_B  = $clog2(SLOT_W);
    localparam int MUTE_W = $clog2(MUTE_LONG + 1);

    port_state_e       state;
    port_state_e       nstate;
    logic [MUTE_W-1:0] mute_cnt;
    logic [SMP_W-1:0]  lat_l;
    logic [SMP_W-1:0]  lat_r;
    logic              sdo_q;
    logic              awake;

    logic              m_evt, m_ws, m_new;
    logic [POS_B-1:0]  m_pos;
    logic              s_evt, s_ws, s_new;
    logic [POS_B-1:0]  s_pos;
    logic              evt, ws_lvl, new_slot;
    logic [POS_B-1:0]  pos;

    logic              left_low;
    logic              chan_left;
    logic              frame_evt;
    logic [SMP_W-1:0]  cur_l;
    logic [SMP_W-1:0]  cur_r;
    logic              nbit;

    // Slot image: sample MSB-first, shifted one position later for the delayed formats.
    function automatic logic bit_at(input logic [SMP_W-1:0] w,
                                    input logic [POS_B-1:0] p,
                                    input logic dly);
        logic [SLOT_W-1:0] img;
        img = {w, (SLOT_W - SMP_W)'(0)} >> dly;
        return img[POS_B'(SLOT_W - 1) - p];
    endfunction

    assign awake = (state != ST_SLEEP);

    aud_ser_mtim #(.SLOT_W(SLOT_W), .SCK_DIV(SCK_DIV)) u_mtim (
        .clk(clk), .rst_n(rst_n), .en(awake && !slave_mode),
        .evt(m_evt), .ws_lvl(m_ws), .pos(m_pos), .new_slot(m_new),
        .sck_o(sck_out), .ws_o(ws_out)
    );

    aud_ser_strk #(.SLOT_W(SLOT_W), .SYNC_STAGES(SYNC_STAGES)) u_strk (
        .clk(clk), .rst_n(rst_n), .en(awake && slave_mode),
        .sck_i(sck_in), .ws_i(ws_in),
        .evt(s_evt), .ws_lvl(s_ws), .pos(s_pos), .new_slot(s_new)
    );

    assign evt      = slave_mode ? s_evt : m_evt;
    assign ws_lvl   = slave_mode ? s_ws  : m_ws;
    assign pos      = slave_mode ? s_pos : m_pos;
    assign new_slot = slave_mode ? s_new : m_new;

    // Polarity: inverted only for slave formats 3 and 4.
    assign left_low  = !fmt_sel ^ (slave_mode && fmt_ext);
    assign chan_left = ws_lvl ^ left_low;
    assign frame_evt = evt && new_slot && (chan_left == !fmt_sel);
    assign cur_l     = frame_evt ? smp_left  : lat_l;
    assign cur_r     = frame_evt ? smp_right : lat_r;
    assign nbit      = bit_at(chan_left ? cur_l : cur_r, pos, !fmt_sel);

    always_comb begin
        nstate = state;
        unique case (state)
            ST_SLEEP: if (!standby) nstate = ST_MUTE;
            ST_MUTE: begin
                if (standby)                                   nstate = ST_SLEEP;
                else if (frame_evt && mute_cnt == MUTE_W'(1))  nstate = ST_RUN;
            end
            ST_RUN:   if (standby) nstate = ST_SLEEP;
            default:  nstate = ST_SLEEP;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_SLEEP;
        else        state <= nstate;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mute_cnt <= MUTE_W'(MUTE_SHORT);
            lat_l    <= '0;
            lat_r    <= '0;
            sdo_q    <= 1'b0;
        end else begin
            if (state == ST_SLEEP)
                mute_cnt <= hpf_on ? MUTE_W'(MUTE_LONG) : MUTE_W'(MUTE_SHORT);
            else if (state == ST_MUTE && frame_evt)
                mute_cnt <= mute_cnt - MUTE_W'(1);
            if (frame_evt) begin
                lat_l <= smp_left;
                lat_r <= smp_right;
            end
            if (nstate != ST_RUN) sdo_q <= 1'b0;
            else if (evt)         sdo_q <= nbit;
        end
    end

    assign sdo    = sdo_q;
    assign sdo_oe = awake;
    assign sck_oe = awake && !slave_mode;
    assign ws_oe  = awake && !slave_mode;

    AST_SLEEP_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
        standby |=> (!sdo_oe && !sck_oe && !ws_oe)); // R8
    AST_MUTE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_MUTE) |-> !sdo); // R9
    AST_SDO_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (!slave_mode && sdo_oe && $past(sdo_oe) && !$stable(sdo)) |-> $fell(sck_out)); // R2
endmodule

// File: tb/aud_ser_tx_tb.sv
module aud_ser_tx_tb;
    localparam int SMP_W  = 18;
    localparam int SLOT_W = 32;

    typedef struct packed {
        logic             slv;
        logic             fs;
        logic             ext;
        logic [SMP_W-1:0] l;
        logic [SMP_W-1:0] r;
    } vec_t;

    // slave, fmt_sel, fmt_ext, left, right
    localparam vec_t VECS [0:7] = '{
        '{1'b0, 1'b1, 1'b0, 18'h2A5C3, 18'h15A3C},
        '{1'b0, 1'b0, 1'b0, 18'h3FFFF, 18'h00001},
        '{1'b0, 1'b1, 1'b1, 18'h20000, 18'h1FFFF},
        '{1'b0, 1'b0, 1'b1, 18'h0F0F0, 18'h30303},
        '{1'b1, 1'b1, 1'b0, 18'h12345, 18'h3CDEF},
        '{1'b1, 1'b0, 1'b0, 18'h00001, 18'h3FFFE},
        '{1'b1, 1'b1, 1'b1, 18'h2AAAA, 18'h15555},
        '{1'b1, 1'b0, 1'b1, 18'h3C00F, 18'h03FF0}
    };

    logic clk = 1'b0;
    logic rst_n, standby, slave_mode, fmt_sel, fmt_ext, hpf_on, sck_in, ws_in;
    logic [SMP_W-1:0] smp_left, smp_right;
    logic sck_out, sck_oe, ws_out, ws_oe, sdo, sdo_oe;
    logic bclk;
    int   checks = 0;
    int   errors = 0;
    int   cyc = 0;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;
    assign bclk = slave_mode ? sck_in : sck_out;

    aud_ser_tx #(.MUTE_SHORT(2), .MUTE_LONG(3)) u_dut (
        .clk(clk), .rst_n(rst_n), .standby(standby), .slave_mode(slave_mode),
        .fmt_sel(fmt_sel), .fmt_ext(fmt_ext), .hpf_on(hpf_on),
        .smp_left(smp_left), .smp_right(smp_right), .sck_in(sck_in), .ws_in(ws_in),
        .sck_out(sck_out), .sck_oe(sck_oe), .ws_out(ws_out), .ws_oe(ws_oe),
        .sdo(sdo), .sdo_oe(sdo_oe)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic sleep_cfg(input logic slv, input logic fs, input logic ext, input logic hpf);
        standby = 1'b1;
        repeat (3) @(negedge clk);
        slave_mode = slv; fmt_sel = fs; fmt_ext = ext; hpf_on = hpf;
        repeat (2) @(negedge clk);
    endtask

    // Receiver: captures whole slots on rising bit clock, checks image and channel mapping.
    task automatic rx_slots(input int nchk, input int skip, input string tag);
        logic        prev, wsv, ll, chl, started, first;
        logic [31:0] img, exp;
        int          cnt, slots;
        ll = !fmt_sel ^ (slave_mode & fmt_ext);
        first = 1'b1; started = 1'b0; slots = 0; cnt = 0; img = '0; prev = 1'b0; chl = 1'b0;
        while (slots < skip + nchk) begin
            @(posedge bclk); #1;
            wsv = slave_mode ? ws_in : ws_out;
            if (first) begin
                prev = wsv; first = 1'b0;
            end else if (wsv != prev) begin
                if (started) begin
                    slots++;
                    if (slots > skip) begin
                        exp = {(chl ? smp_left : smp_right), 14'b0} >> (!fmt_sel);
                        chk(img == exp && cnt == SLOT_W, tag, img, exp);
                    end
                end
                started = 1'b1; chl = wsv ^ ll; prev = wsv; cnt = 0; img = '0;
            end
            if (started) begin img = {img[30:0], sdo}; cnt++; end
        end
    endtask

    task automatic drv_slave(input int frames, input logic first_ws, input int idle_frame);
        for (int f = 0; f < frames; f++)
            for (int h = 0; h < 2; h++)
                for (int b = 0; b < SLOT_W; b++) begin
                    @(negedge clk);
                    sck_in = 1'b0;
                    if (b == 0) ws_in = h[0] ? !first_ws : first_ws;
                    repeat (4) @(negedge clk);
                    if (f == idle_frame && h == 0 && b == 10) repeat (40) @(negedge clk); // R6 idle
                    sck_in = 1'b1;
                    repeat (3) @(negedge clk);
                end
    endtask

    task automatic cap32(output logic [31:0] v);
        v = '0;
        for (int i = 0; i < 32; i++) begin
            @(posedge sck_out); #1;
            v = {v[30:0], sdo};
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic        fwl, llv, fws;
        logic [31:0] v;
        int          k, c1;
        rst_n = 1'b0; standby = 1'b1; slave_mode = 1'b0; fmt_sel = 1'b1; fmt_ext = 1'b0;
        hpf_on = 1'b0; sck_in = 1'b0; ws_in = 1'b0; smp_left = '0; smp_right = '0;
        repeat (5) @(negedge clk);
        chk(!sdo_oe && !sck_oe && !ws_oe, "R10 reset enables", {sdo_oe, sck_oe, ws_oe}, 0);
        chk(sdo == 1'b0, "R10 reset data", sdo, 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        chk(!sdo_oe && !sck_oe && !ws_oe, "R8 standby enables", {sdo_oe, sck_oe, ws_oe}, 0);

        // Table walk: every format in both modes.
        for (int i = 0; i < 8; i++) begin
            sleep_cfg(VECS[i].slv, VECS[i].fs, VECS[i].ext, 1'b0);
            smp_left = VECS[i].l; smp_right = VECS[i].r;
            fwl = !VECS[i].fs;
            llv = !VECS[i].fs ^ (VECS[i].slv & VECS[i].ext);
            fws = fwl ? !llv : llv;
            if (VECS[i].slv) begin sck_in = 1'b1; ws_in = !fws; end
            repeat (4) @(negedge clk);
            standby = 1'b0;
            if (VECS[i].slv)
                fork
                    drv_slave(4, fws, (i == 7) ? 2 : -1);
                    rx_slots(4, 1, "R2,R3,R4,R6 slave slot");
                join
            else
                rx_slots(4, 1, VECS[i].ext ? "R2,R3,R4,R5 master slot" : "R2,R3,R4 master slot");
            chk(sdo_oe && (sck_oe == !VECS[i].slv) && (ws_oe == !VECS[i].slv),
                "R1,R6 drive enables", {sdo_oe, sck_oe, ws_oe}, {1'b1, !VECS[i].slv, !VECS[i].slv});
        end

        // R1 clock ratios in master mode.
        sleep_cfg(1'b0, 1'b1, 1'b0, 1'b0);
        standby = 1'b0;
        @(posedge sck_out); #1; c1 = cyc;
        @(posedge sck_out); #1;
        chk(cyc - c1 == 4, "R1 bit clock period", cyc - c1, 4);
        @(posedge ws_out); #1; c1 = cyc;
        @(negedge ws_out); #1;
        chk(cyc - c1 == 128, "R1 word select half", cyc - c1, 128);

        // R9 mute lengths, format 1 so the right MSB leads the frame.
        for (int h = 0; h < 2; h++) begin
            sleep_cfg(1'b0, 1'b1, 1'b0, h[0]);
            smp_right = 18'h20000; smp_left = 18'h3FFFF;
            standby = 1'b0;
            k = 0;
            do begin @(posedge clk); #1; k++; end while (sdo !== 1'b1 && k < 2000);
            chk(k == (h ? 514 : 258), "R9 first data edge", k, h ? 514 : 258);
        end

        // R7 frame latch: change samples mid right slot (format 1, right first).
        smp_left = 18'h11111; smp_right = 18'h22222;
        @(negedge ws_out); #1;
        repeat (40) @(negedge clk);
        smp_left = 18'h33333; smp_right = 18'h04444;
        @(posedge ws_out); #1;
        cap32(v);
        chk(v == {18'h11111, 14'b0}, "R7 left from frame start", v, {18'h11111, 14'b0});
        cap32(v);
        chk(v == {18'h04444, 14'b0}, "R7 next frame right", v, {18'h04444, 14'b0});

        // R8 standby during run.
        @(negedge clk); standby = 1'b1;
        @(negedge clk);
        chk(!sdo_oe && !sck_oe && !ws_oe, "R8 standby from run", {sdo_oe, sck_oe, ws_oe}, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule